// File: doc/BRIEF.md
# Byte-Opcode SPI Master Sequencer

This block is a half-duplex SPI master whose transfers are described by a small program, not built into fixed logic. Software loads a 64-bit program word of eight one-byte opcodes into the sequence register, and the write starts execution. The engine then selects or releases a peripheral, shifts bytes out of an 8-byte transmit register, shifts bytes into an 8-byte receive register, and repeats earlier slots with a counted branch. It ends on a stop opcode, on an opcode it does not recognise, or after the last slot.

Software and engine hand data over through full flags on the transmit and receive registers. Software writes a transmit word, and the engine clears the transmit-full flag once it has shifted that word out. The engine sets the receive-full flag when a received word is ready, and a read of the receive register clears it. The engine waits whenever a flag says it may not go on, so a long transfer runs as a loop of short shift opcodes paced by software. SCK runs in mode 0 with a programmable divider. Up to 15 active-low chip selects are provided.

All registers are 64 bits wide and sit behind a simple register port. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `spi_seq_master`

## Requirements
- R1: After reset, status reads 0x0001_0000_0000_0000 (only the idle bit 48 set), all chip selects are high, and SCK and MOSI are low.
- R2: The register addresses are 0 counter config, 1 clock config, 2 transmit, 3 receive, 4 sequence and 5 status. Counter config and clock config read back what was written. A sequence write while idle starts execution at slot 0 (bits 63:56), and later slots follow toward slot 7 (bits 7:0). A sequence write while the engine is busy is ignored.
- R3: Opcode 0x1n with n=0 drives every chip select high. With n from 1 to 15 it drives only cs_n_o[n-1] low. A selection stays in force after the program ends.
- R4: Opcode 0x3n (n 1..8) shifts out n bytes MSB first, starting at transmit bits 63:56. MOSI holds steady for the whole time SCK is high. When the shift ends, transmit-full (status bit 59) clears.
- R5: Opcode 0x4n (n 1..8) samples MISO on SCK rising edges, MSB first. The n bytes are stored right-aligned in the receive register with the upper bits zero, and receive-full (status bit 63) is set. A read of address 3 clears bit 63.
- R6: Opcode 0xEn (n 0..7) jumps to slot n and decrements the loop counter while the counter is nonzero. Otherwise it falls through to the next slot. The counter is loaded from counter config bits 39:32 when the program starts.
- R7: Each SCK high and low phase lasts divider+1 clocks. The divider is held in clock config bits 63:52.
- R8: A shift-out waits while transmit-full is clear. A shift-in waits while receive-full is set. While it waits, the state field shows 0x04 and SCK stays low.
- R9: A transmit write while transmit-full is set leaves the held word unchanged and sets overrun bit 58. A receive read while receive-full is clear sets underrun bit 61.
- R10: A status write of all zeros clears bits 58 and 61. A nonzero status write leaves them as they are.
- R11: A clock config write with bits 36 and 38 set, followed by a clock config write with bits 37 and 39 set, returns the engine to idle. It also drives all chip selects high and clears bits 63, 61, 59 and 58. The second write alone has no such effect.
- R12: The status state field (bits 55:48) is one-hot: 0x01 idle, 0x02 decode, 0x04 wait, 0x08 shift. The engine halts and leaves the chip selects as they are on opcode 0x00 and on any opcode outside 0x1n, 0x31-0x38, 0x41-0x48 and 0xE0-0xE7. It also halts after slot 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects on receive register) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data, combinational |
| sck_o | output | 1 | SPI clock, mode 0 |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | NCS | Active-low chip selects |

## Verification
The hardest situations to reach are an engine parked partway through a program and the handshake races around it. The stimulus parks the engine on purpose. It starts a shift-out program with the transmit register empty, or it runs two shift-ins back to back without reading the first result. With the engine parked, the bench checks that SCK stays quiet and that a second sequence write is ignored. It then checks that a lone second reset write does nothing and that the full two-step reset recovers. The counted loop is driven by feeding one transmit word per iteration and polling the full flag between words, so branch-taken and fall-through paths both run against the bench's bit-level slave.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int WORD_W = 64;
  localparam int OP_W   = 8;
  localparam int SLOTS  = WORD_W / OP_W;
  localparam int PC_W   = $clog2(SLOTS) + 1;
  localparam int ADDR_W = 3;
  localparam int LOOP_W = 8;
  localparam int LOOP_LSB = 32;

  localparam logic [ADDR_W-1:0] A_CNT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLK  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TX   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RX   = 3'd3;
  localparam logic [ADDR_W-1:0] A_SEQ  = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;

  localparam int B_RX_FULL = 63;
  localparam int B_RX_UNR  = 61;
  localparam int B_TX_FULL = 59;
  localparam int B_TX_OVR  = 58;
  localparam int B_STATE   = 48;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'b0001,
    ST_DECODE = 4'b0010,
    ST_WAIT   = 4'b0100,
    ST_SHIFT  = 4'b1000
  } eng_state_e;
endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
  import spi_seq_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  output logic [WORD_W-1:0]    rdata_o,
  input  eng_state_e           state_i,
  input  logic                 tx_consume_i,
  input  logic                 rx_load_i,
  input  logic [WORD_W-1:0]    rx_data_i,
  output logic [LOOP_W-1:0]    loop_o,
  output logic [DIV_W-1:0]     div_o,
  output logic [WORD_W-1:0]    tx_data_o,
  output logic [WORD_W-1:0]    seq_o,
  output logic                 seq_start_o,
  output logic                 tx_full_o,
  output logic                 rx_full_o,
  output logic                 soft_rst_o
);
  logic [WORD_W-1:0] cnt_cfg_q, clk_cfg_q, tx_q, rx_q, seq_q, stat_w;
  logic tx_full_q, rx_full_q, tx_ovr_q, rx_unr_q, arm_q;
  logic wr_cnt, wr_clk, wr_tx, wr_stat, rd_rx, rst1_pat, rst2_pat;

  assign wr_cnt   = wr_i && addr_i == A_CNT;
  assign wr_clk   = wr_i && addr_i == A_CLK;
  assign wr_tx    = wr_i && addr_i == A_TX;
  assign wr_stat  = wr_i && addr_i == A_STAT;
  assign rd_rx    = rd_i && addr_i == A_RX;
  assign rst1_pat = wdata_i[36] && wdata_i[38];
  assign rst2_pat = wdata_i[37] && wdata_i[39];

  assign seq_start_o = wr_i && addr_i == A_SEQ && state_i == ST_IDLE;
  assign soft_rst_o  = wr_clk && arm_q && rst2_pat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_cfg_q <= '0;
      clk_cfg_q <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      seq_q     <= '0;
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
      tx_ovr_q  <= 1'b0;
      rx_unr_q  <= 1'b0;
      arm_q     <= 1'b0;
    end else begin
      if (wr_cnt) cnt_cfg_q <= wdata_i;
      if (wr_clk) begin
        clk_cfg_q <= wdata_i;
        arm_q     <= rst1_pat;
      end
      if (seq_start_o) seq_q <= wdata_i;
      if (soft_rst_o) begin
        tx_full_q <= 1'b0;
        rx_full_q <= 1'b0;
        tx_ovr_q  <= 1'b0;
        rx_unr_q  <= 1'b0;
      end else begin
        if (tx_consume_i) tx_full_q <= 1'b0;
        if (wr_tx) begin
          if (tx_full_q) tx_ovr_q <= 1'b1;
          else begin
            tx_q      <= wdata_i;
            tx_full_q <= 1'b1;
          end
        end
        if (rd_rx) begin
          if (rx_full_q) rx_full_q <= 1'b0;
          else           rx_unr_q  <= 1'b1;
        end
        if (rx_load_i) begin
          rx_q      <= rx_data_i;
          rx_full_q <= 1'b1;
        end
        if (wr_stat && wdata_i == '0) begin
          tx_ovr_q <= 1'b0;
          rx_unr_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    stat_w = '0;
    stat_w[B_RX_FULL] = rx_full_q;
    stat_w[B_RX_UNR]  = rx_unr_q;
    stat_w[B_TX_FULL] = tx_full_q;
    stat_w[B_TX_OVR]  = tx_ovr_q;
    stat_w[B_STATE +: 8] = {4'b0000, state_i};
  end

  always_comb begin
    unique case (addr_i)
      A_CNT:   rdata_o = cnt_cfg_q;
      A_CLK:   rdata_o = clk_cfg_q;
      A_TX:    rdata_o = tx_q;
      A_RX:    rdata_o = rx_q;
      A_SEQ:   rdata_o = seq_q;
      A_STAT:  rdata_o = stat_w;
      default: rdata_o = '0;
    endcase
  end

  assign loop_o    = cnt_cfg_q[LOOP_LSB +: LOOP_W];
  assign div_o     = clk_cfg_q[WORD_W-1 -: DIV_W];
  assign tx_data_o = tx_q;
  assign seq_o     = seq_q;
  assign tx_full_o = tx_full_q;
  assign rx_full_o = rx_full_q;

  assert_tx_full_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_full_q) |-> $past(tx_consume_i || soft_rst_o));
  assert_rx_full_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_q) |-> $past(rx_load_i));
  assert_tx_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_q && !tx_consume_i && !soft_rst_o |=> $stable(tx_q));
  assert_err_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_ovr_q) || $fell(rx_unr_q) |-> $past(soft_rst_o || (wr_stat && wdata_i == '0)));
endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter
  import spi_seq_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic              dir_out_i,
  input  logic [3:0]        nbytes_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              sck_o,
  output logic              mosi_o
);
  localparam int BC_W = $clog2(WORD_W) + 1;

  logic busy_q, ph_q, out_q, done_q, tick;
  logic [DIV_W-1:0]  div_cnt_q;
  logic [BC_W-1:0]   bit_cnt_q, last_bit_q;
  logic [WORD_W-1:0] sh_q;

  assign tick = busy_q && div_cnt_q == div_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      ph_q       <= 1'b0;
      out_q      <= 1'b0;
      done_q     <= 1'b0;
      div_cnt_q  <= '0;
      bit_cnt_q  <= '0;
      last_bit_q <= '0;
      sh_q       <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
        ph_q   <= 1'b0;
      end else if (start_i) begin
        busy_q     <= 1'b1;
        ph_q       <= 1'b0;
        out_q      <= dir_out_i;
        div_cnt_q  <= '0;
        bit_cnt_q  <= '0;
        last_bit_q <= BC_W'({nbytes_i, 3'b000}) - BC_W'(1);
        sh_q       <= dir_out_i ? tx_word_i : '0;
      end else if (busy_q) begin
        if (tick) begin
          div_cnt_q <= '0;
          if (!ph_q) begin
            ph_q <= 1'b1;
            if (!out_q) sh_q <= {sh_q[WORD_W-2:0], miso_i};
          end else begin
            ph_q      <= 1'b0;
            bit_cnt_q <= bit_cnt_q + BC_W'(1);
            if (out_q) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
            if (bit_cnt_q == last_bit_q) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end else begin
          div_cnt_q <= div_cnt_q + DIV_W'(1);
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_word_o = sh_q;
  assign sck_o     = ph_q;
  assign mosi_o    = busy_q && out_q && sh_q[WORD_W-1];

  assert_bit_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> bit_cnt_q <= last_bit_q);
  assert_sck_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick && !abort_i && !start_i |=> $stable(ph_q));
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
  import spi_seq_pkg::*;
#(
  parameter int NCS = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              start_i,
  input  logic [WORD_W-1:0] seq_i,
  input  logic [LOOP_W-1:0] loop_i,
  input  logic              tx_full_i,
  input  logic              rx_full_i,
  input  logic              sh_busy_i,
  input  logic              sh_done_i,
  output logic              sh_start_o,
  output logic              sh_dir_out_o,
  output logic [3:0]        sh_nbytes_o,
  output logic              tx_consume_o,
  output logic              rx_load_o,
  output eng_state_e        state_o,
  output logic [NCS-1:0]    cs_n_o
);
  eng_state_e        state_q;
  logic [PC_W-1:0]   pc_q;
  logic [LOOP_W-1:0] loop_q;
  logic [NCS-1:0]    cs_n_q;
  logic [3:0]        nbytes_q;
  logic              dir_q, ready;
  logic [WORD_W-1:0] seq_sh;
  logic [OP_W-1:0]   op;
  logic [3:0]        arg;

  assign seq_sh = seq_i << {pc_q[PC_W-2:0], 3'b000};
  assign op     = seq_sh[WORD_W-1 -: OP_W];
  assign arg    = op[3:0];
  assign ready  = dir_q ? tx_full_i : !rx_full_i;

  function automatic logic [NCS-1:0] cs_decode(input logic [3:0] n);
    logic [NCS-1:0] c;
    for (int i = 0; i < NCS; i++) c[i] = !(n == 4'(i + 1));
    return c;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      pc_q     <= '0;
      loop_q   <= '0;
      cs_n_q   <= '1;
      nbytes_q <= '0;
      dir_q    <= 1'b0;
    end else if (soft_rst_i) begin
      state_q <= ST_IDLE;
      cs_n_q  <= '1;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pc_q    <= '0;
          loop_q  <= loop_i;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          if (pc_q[PC_W-1]) state_q <= ST_IDLE;
          else begin
            unique case (op[7:4])
              4'h1: begin
                cs_n_q <= cs_decode(arg);
                pc_q   <= pc_q + PC_W'(1);
              end
              4'h3, 4'h4: begin
                if (arg != 4'd0 && arg <= 4'd8) begin
                  dir_q    <= op[7:4] == 4'h3;
                  nbytes_q <= arg;
                  state_q  <= ST_WAIT;
                end else state_q <= ST_IDLE;
              end
              4'hE: begin
                if (arg[3]) state_q <= ST_IDLE;
                else if (loop_q != '0) begin
                  loop_q <= loop_q - LOOP_W'(1);
                  pc_q   <= {1'b0, arg[2:0]};
                end else pc_q <= pc_q + PC_W'(1);
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
        ST_WAIT: if (ready) state_q <= ST_SHIFT;
        ST_SHIFT: if (sh_done_i) begin
          pc_q    <= pc_q + PC_W'(1);
          state_q <= ST_DECODE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sh_start_o   = state_q == ST_WAIT && ready && !soft_rst_i;
  assign sh_dir_out_o = dir_q;
  assign sh_nbytes_o  = nbytes_q;
  assign tx_consume_o = state_q == ST_SHIFT && sh_done_i && dir_q;
  assign rx_load_o    = state_q == ST_SHIFT && sh_done_i && !dir_q;
  assign state_o      = state_q;
  assign cs_n_o       = cs_n_q;

  assert_state_onehot_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(state_q));
  assert_tx_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_start_o && sh_dir_out_o |-> tx_full_i);
  assert_rx_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_start_o && !sh_dir_out_o |-> !rx_full_i);
  assert_shift_live_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SHIFT |-> sh_busy_i || sh_done_i);
  assert_cs_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> &cs_n_q && state_q == ST_IDLE);
endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master
  import spi_seq_pkg::*;
#(
  parameter int NCS   = 15,
  parameter int DIV_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NCS-1:0]    cs_n_o
);
  eng_state_e        state;
  logic [LOOP_W-1:0] loop;
  logic [DIV_W-1:0]  div;
  logic [WORD_W-1:0] tx_data, seq, rx_word;
  logic seq_start, tx_full, rx_full, soft_rst;
  logic sh_start, sh_dir_out, sh_busy, sh_done, tx_consume, rx_load;
  logic [3:0] sh_nbytes;

  spi_seq_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .state_i(state), .tx_consume_i(tx_consume), .rx_load_i(rx_load),
    .rx_data_i(rx_word), .loop_o(loop), .div_o(div), .tx_data_o(tx_data),
    .seq_o(seq), .seq_start_o(seq_start), .tx_full_o(tx_full),
    .rx_full_o(rx_full), .soft_rst_o(soft_rst)
  );

  spi_seq_engine #(.NCS(NCS)) u_engine (
    .clk_i, .rst_ni,
    .soft_rst_i(soft_rst), .start_i(seq_start), .seq_i(seq), .loop_i(loop),
    .tx_full_i(tx_full), .rx_full_i(rx_full),
    .sh_busy_i(sh_busy), .sh_done_i(sh_done),
    .sh_start_o(sh_start), .sh_dir_out_o(sh_dir_out), .sh_nbytes_o(sh_nbytes),
    .tx_consume_o(tx_consume), .rx_load_o(rx_load),
    .state_o(state), .cs_n_o(cs_n_o)
  );

  spi_seq_shifter #(.DIV_W(DIV_W)) u_shifter (
    .clk_i, .rst_ni,
    .abort_i(soft_rst), .start_i(sh_start), .dir_out_i(sh_dir_out),
    .nbytes_i(sh_nbytes), .tx_word_i(tx_data), .div_i(div), .miso_i,
    .busy_o(sh_busy), .done_o(sh_done), .rx_word_o(rx_word),
    .sck_o, .mosi_o
  );
endmodule

// File: tb/spi_seq_master_tb_top.sv
module spi_seq_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0, miso = 1'b0;
  logic [2:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic sck, mosi;
  logic [NCS-1:0] cs_n;

  int checks = 0, fails = 0, cycles = 0;
  int exp_half = 1, high_cnt = 0, rise_cnt = 0;
  logic sck_prev = 1'b0, cap_bit = 1'b0, stab_err = 1'b0;
  bit mosi_bits[$];
  bit miso_bits[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_seq_master #(.NCS(NCS), .DIV_W(12)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // per-clock slave model and SCK timing reference
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog", 64'(cycles), 64'd150000);
      finish_run();
    end
    if (rst_n) begin
      if (sck && !sck_prev) begin
        rise_cnt++;
        mosi_bits.push_back(mosi);
        cap_bit  = mosi;
        stab_err = 1'b0;
        high_cnt = 1;
        if (miso_bits.size() > 0) void'(miso_bits.pop_front());
      end else if (sck && sck_prev) begin
        high_cnt++;
        if (mosi != cap_bit) stab_err = 1'b1;
      end else if (!sck && sck_prev) begin
        check(high_cnt == exp_half, "R7 SCK high phase", 64'(high_cnt), 64'(exp_half));
        check(!stab_err, "R4 MOSI stable while SCK high", 64'(stab_err), 64'd0);
      end
      sck_prev = sck;
    end
    miso = (miso_bits.size() > 0) ? miso_bits[0] : 1'b0;
  end

  task automatic wr_reg(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [63:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [63:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd_reg(3'd5, s);
      if (s[48]) break;
    end
  endtask

  task automatic push_rx(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) miso_bits.push_back(b[i]);
  endtask

  function automatic logic [63:0] pop_bits(input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[62:0], 1'(mosi_bits.pop_front())};
    return v;
  endfunction

  task automatic set_div(input int d);
    exp_half = d + 1;
    wr_reg(3'd1, 64'(d) << 52);
  endtask

  initial begin
    logic [63:0] v;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(3'd5, v);
    check(v == 64'h0001_0000_0000_0000, "R1 status after reset", v, 64'h0001_0000_0000_0000);
    check(cs_n == '1 && !sck && !mosi, "R1 pins idle", {cs_n, sck, mosi}, {15'h7fff, 2'b00});

    // R2 register readback
    wr_reg(3'd0, 64'hA5A5_0000_1234_0F00);
    rd_reg(3'd0, v);
    check(v == 64'hA5A5_0000_1234_0F00, "R2 counter config readback", v, 64'hA5A5_0000_1234_0F00);
    set_div(1);
    rd_reg(3'd1, v);
    check(v == 64'h0010_0000_0000_0000, "R2 clock config readback", v, 64'h0010_0000_0000_0000);
    wr_reg(3'd0, 64'h0);

    // R4 / R3: three-byte shift-out on line 0
    mosi_bits.delete();
    wr_reg(3'd2, 64'hC35A_0F00_0000_0000);
    wr_reg(3'd4, 64'h1133_0000_0000_0000);
    wait_idle();
    check(mosi_bits.size() == 24, "R4 bit count", 64'(mosi_bits.size()), 64'd24);
    v = pop_bits(24);
    check(v == 64'hC35A0F, "R4 shift-out bytes", v, 64'hC35A0F);
    check(cs_n == 15'h7ffe, "R3 line 0 stays selected", 64'(cs_n), 64'h7ffe);
    rd_reg(3'd5, v);
    check(v[59] == 1'b0, "R4 tx full cleared", 64'(v[59]), 64'd0);
    wr_reg(3'd4, 64'h1000_0000_0000_0000);
    wait_idle();
    check(cs_n == '1, "R3 deselect all", 64'(cs_n), 64'h7fff);
    wr_reg(3'd4, 64'h1F00_0000_0000_0000);
    wait_idle();
    check(cs_n == 15'h3fff, "R3 line 14 select", 64'(cs_n), 64'h3fff);

    // R5 shift-in two bytes
    push_rx(8'hA1); push_rx(8'h7E);
    wr_reg(3'd4, 64'h1242_1000_0000_0000);
    wait_idle();
    rd_reg(3'd5, v);
    check(v[63] == 1'b1, "R5 rx full set", 64'(v[63]), 64'd1);
    check(cs_n == '1, "R3 program deselect", 64'(cs_n), 64'h7fff);
    rd_reg(3'd3, v);
    check(v == 64'hA17E, "R5 right-aligned rx", v, 64'hA17E);
    rd_reg(3'd5, v);
    check(v[63] == 1'b0 && v[61] == 1'b0, "R5 rx full cleared by read", v[63:56], 8'h00);

    // R6 counted loop, one byte per pass
    mosi_bits.delete();
    wr_reg(3'd0, 64'h0000_0002_0000_0000);
    wr_reg(3'd4, 64'h1131_E110_0000_0000);
    foreach (v[i]) begin end
    for (int k = 0; k < 3; k++) begin
      logic [7:0] b;
      b = (k == 0) ? 8'h81 : (k == 1) ? 8'h42 : 8'h24;
      wr_reg(3'd2, {b, 56'h0});
      for (int i = 0; i < 2000; i++) begin
        rd_reg(3'd5, v);
        if (!v[59]) break;
      end
    end
    wait_idle();
    check(mosi_bits.size() == 24, "R6 three loop passes", 64'(mosi_bits.size()), 64'd24);
    v = pop_bits(24);
    check(v == 64'h814224, "R6 loop data", v, 64'h814224);
    check(cs_n == '1, "R6 fall-through reached deselect", 64'(cs_n), 64'h7fff);
    wr_reg(3'd0, 64'h0);

    // R8 shift-out stall with empty transmit register
    mosi_bits.delete();
    wr_reg(3'd4, 64'h1131_1000_0000_0000);
    r0 = rise_cnt;
    repeat (40) @(negedge clk);
    rd_reg(3'd5, v);
    check(v[55:48] == 8'h04, "R8 waiting on tx", 64'(v[55:48]), 64'h04);
    check(rise_cnt == r0 && !sck, "R8 SCK quiet while waiting", 64'(rise_cnt - r0), 64'd0);
    wr_reg(3'd2, 64'h9900_0000_0000_0000);
    wait_idle();
    v = pop_bits(8);
    check(v == 64'h99, "R8 resumes after tx write", v, 64'h99);

    // R8 shift-in stall while receive register full
    push_rx(8'h3C); push_rx(8'hC3);
    wr_reg(3'd4, 64'h1141_4110_0000_0000);
    repeat (120) @(negedge clk);
    rd_reg(3'd5, v);
    check(v[63] && v[55:48] == 8'h04, "R8 waiting on rx full", v[63:48], 16'h8004);
    rd_reg(3'd3, v);
    check(v == 64'h3C, "R5 first rx byte", v, 64'h3C);
    wait_idle();
    rd_reg(3'd3, v);
    check(v == 64'hC3, "R5 second rx byte", v, 64'hC3);

    // R9 / R10 overrun, underrun, clearing
    mosi_bits.delete();
    wr_reg(3'd2, 64'h5500_0000_0000_0000);
    wr_reg(3'd2, 64'hAA00_0000_0000_0000);
    rd_reg(3'd3, v);
    rd_reg(3'd5, v);
    check(v[58] && v[59] && v[61], "R9 overrun and underrun flags", v[63:56], 8'h2C);
    wr_reg(3'd5, 64'h1);
    rd_reg(3'd5, v);
    check(v[58] && v[61], "R10 nonzero write keeps flags", v[63:56], 8'h2C);
    wr_reg(3'd5, 64'h0);
    rd_reg(3'd5, v);
    check(!v[58] && !v[61] && v[59], "R10 zero write clears flags", v[63:56], 8'h08);
    wr_reg(3'd4, 64'h1131_1000_0000_0000);
    wait_idle();
    v = pop_bits(8);
    check(v == 64'h55, "R9 held tx word kept", v, 64'h55);

    // R2 ignored start while busy, R11 two-step reset
    wr_reg(3'd4, 64'h1131_1000_0000_0000);
    wr_reg(3'd4, 64'h1F00_0000_0000_0000);
    repeat (5) @(negedge clk);
    check(cs_n == 15'h7ffe, "R2 busy sequence write ignored", 64'(cs_n), 64'h7ffe);
    rd_reg(3'd3, v);
    wr_reg(3'd1, 64'h0000_00A0_0000_0000);
    rd_reg(3'd5, v);
    check(v[55:48] == 8'h04 && v[61], "R11 lone second step no effect", v[63:48], 16'h2004);
    wr_reg(3'd1, 64'h0000_0050_0000_0000);
    wr_reg(3'd1, 64'h0000_00A0_0000_0000);
    rd_reg(3'd5, v);
    check(v == 64'h0001_0000_0000_0000, "R11 reset status", v, 64'h0001_0000_0000_0000);
    check(cs_n == '1, "R11 reset releases selects", 64'(cs_n), 64'h7fff);
    set_div(1);

    // R12 halting opcodes and slot-7 end
    wr_reg(3'd4, 64'h1125_1000_0000_0000);
    wait_idle();
    check(cs_n == 15'h7ffe, "R12 undefined opcode halts", 64'(cs_n), 64'h7ffe);
    wr_reg(3'd4, 64'h1230_1000_0000_0000);
    wait_idle();
    check(cs_n == 15'h7ffd, "R12 zero-length shift halts", 64'(cs_n), 64'h7ffd);
    wr_reg(3'd4, 64'h1011_1011_1011_1012);
    wait_idle();
    check(cs_n == 15'h7ffd, "R12 all eight slots run", 64'(cs_n), 64'h7ffd);

    // R7 slower divider
    set_div(3);
    mosi_bits.delete();
    wr_reg(3'd2, 64'h6C00_0000_0000_0000);
    wr_reg(3'd4, 64'h1131_1000_0000_0000);
    wait_idle();
    v = pop_bits(8);
    check(v == 64'h6C, "R7 data at divider 3", v, 64'h6C);

    finish_run();
  end
endmodule